// File: doc/BRIEF.md
# Two-Bank Data Register File with Shared General-Purpose RAM

This block is the 8-bit data memory of a small accumulator-style CPU core. The core presents a 7-bit offset taken from the instruction, together with a write strobe and write data. The block forms a full 8-bit address by placing the current bank bit above that offset. The bank bit lives in a status register that the block holds itself. Offset 00h is the indirect slot: an access to it uses the 7-bit pointer held in the block's file-select register instead of the instruction offset. The bank bit still applies to an indirect access.

The first twelve offsets of each bank form the special-function window. Three of those offsets are handled inside the block: the indirect slot, the status register and the pointer register, and all three look the same from either bank. The other window offsets go out to an external special-function port, which has an address, a write strobe and write data, and which returns read data. Offsets from 0Ch upward are general-purpose RAM, sized by a parameter. Bank 1 and bank 0 reach the same physical cell at a given offset, so for example 0Ch and 8Ch are one byte. Writes take effect on the clock edge. Reads are combinational from the address currently formed.

Top module: `banked_regfile`

## Requirements
- R1: While reset (rst_n low) is applied, and on leaving it, the bank bit and the 8-bit pointer register are 0.
- R2: Writing offset 03h (the status register) sets the bank bit from write data bit 5. Reading offset 03h returns the bank bit at bit 5 and 0 in every other bit. The bank bit is also driven on `bank_sel`. Both banks behave the same.
- R3: Offset 04h reads and writes the 8-bit pointer register, which is driven on `fsr_ptr`. Both banks behave the same.
- R4: Offsets 0Ch through 0Ch+GPR_BYTES-1 are general-purpose bytes. A write lands on the clock edge, and the new value is read back combinationally on the following cycle.
- R5: A general-purpose offset reaches the same byte in bank 1 as in bank 0.
- R6: An access to offset 00h acts on offset `fsr_ptr[6:0]`, within the bank chosen by the current bank bit.
- R7: An indirect access whose pointer is 00h reads 00h. Writing it changes nothing and raises no external write strobe.
- R8: An access that resolves to offset 01h, 02h or 05h–0Bh drives `sfr_addr` = {bank bit, offset}, passes write data and the write strobe to the external port, and returns `sfr_rdata`. General-purpose RAM is not touched.
- R9: Offsets from 0Ch+GPR_BYTES up to 7Fh read 00h, and writes to them are ignored.
- R10: `sfr_we` is high only for a write that resolves to an external window offset (01h, 02h, 05h–0Bh).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | 7 | Offset from the instruction; 00h selects indirect access |
| acc_we | input | 1 | Write strobe for the current access |
| acc_wdata | input | 8 | Byte to write |
| acc_rdata | output | 8 | Byte read from the resolved location |
| sfr_addr | output | 8 | Full banked address of the resolved location |
| sfr_we | output | 1 | Write strobe toward the external special-function registers |
| sfr_wdata | output | 8 | Write data toward the external special-function registers |
| sfr_rdata | input | 8 | Read data returned by the external special-function registers |
| bank_sel | output | 1 | Current bank bit |
| fsr_ptr | output | 8 | Current pointer register value |

## Verification
The bench builds the block with GPR_BYTES at its default of 68, so the general-purpose bytes run from 0Ch to 4Fh. That leaves 50h–7Fh unimplemented, where the read-zero and write-ignore behaviour can be reached both directly and through the pointer. Because the pointer's seven low bits sweep the whole offset range, random indirect accesses reach the self-referencing slot, the internal status and pointer registers, the external window and both bank images of every general-purpose byte.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int GPR_BYTES  = 68,
  parameter int SFR_TOP    = 12,
  parameter int STATUS_OFS = 3,
  parameter int FSR_OFS    = 4,
  parameter int BANK_BIT   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] acc_addr,
  input  logic       acc_we,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic [7:0] sfr_addr,
  output logic       sfr_we,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata,
  output logic       bank_sel,
  output logic [7:0] fsr_ptr
);
  localparam int         IDX_W   = (GPR_BYTES > 1) ? $clog2(GPR_BYTES) : 1;
  localparam logic [6:0] SFR_END = 7'(SFR_TOP);
  localparam logic [7:0] GPR_LIM = 8'(GPR_BYTES);

  logic             rp0_q;
  logic [7:0]       fsr_q;
  logic [7:0]       gpr_mem [GPR_BYTES];

  logic [6:0]       eff_ofs;
  logic [6:0]       gpr_off;
  logic [IDX_W-1:0] gpr_idx;
  logic             hit_null, hit_status, hit_fsr, hit_sfr, hit_gpr;
  logic [7:0]       status_rd;

  assign eff_ofs    = (acc_addr == 7'd0) ? fsr_q[6:0] : acc_addr;
  assign gpr_off    = eff_ofs - SFR_END;
  assign gpr_idx    = gpr_off[IDX_W-1:0];

  assign hit_null   = (eff_ofs == 7'd0);
  assign hit_status = (eff_ofs == 7'(STATUS_OFS));
  assign hit_fsr    = (eff_ofs == 7'(FSR_OFS));
  assign hit_sfr    = (eff_ofs < SFR_END) && !hit_null && !hit_status && !hit_fsr;
  assign hit_gpr    = (eff_ofs >= SFR_END) && ({1'b0, gpr_off} < GPR_LIM);

  assign status_rd  = {7'd0, rp0_q} << BANK_BIT;

  always_comb begin
    if (hit_status)   acc_rdata = status_rd;
    else if (hit_fsr) acc_rdata = fsr_q;
    else if (hit_sfr) acc_rdata = sfr_rdata;
    else if (hit_gpr) acc_rdata = gpr_mem[gpr_idx];
    else              acc_rdata = 8'h00;
  end

  assign sfr_addr  = {rp0_q, eff_ofs};
  assign sfr_we    = acc_we && hit_sfr;
  assign sfr_wdata = acc_wdata;
  assign bank_sel  = rp0_q;
  assign fsr_ptr   = fsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp0_q <= 1'b0;
      fsr_q <= 8'h00;
    end else if (acc_we) begin
      if (hit_status) rp0_q <= acc_wdata[BANK_BIT];
      if (hit_fsr)    fsr_q <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_we && hit_gpr) gpr_mem[gpr_idx] <= acc_wdata;
  end
endmodule

module banked_regfile_chk #(
  parameter int GPR_BYTES  = 68,
  parameter int SFR_TOP    = 12,
  parameter int STATUS_OFS = 3,
  parameter int FSR_OFS    = 4,
  parameter int BANK_BIT   = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] acc_addr,
  input logic       acc_we,
  input logic [7:0] acc_wdata,
  input logic [7:0] acc_rdata,
  input logic [7:0] sfr_addr,
  input logic       sfr_we,
  input logic [7:0] sfr_rdata,
  input logic       bank_sel,
  input logic [7:0] fsr_ptr
);
  localparam logic [7:0] UNIMP_LO = 8'(SFR_TOP + GPR_BYTES);
  localparam logic [6:0] SFR_END  = 7'(SFR_TOP);
  localparam logic [6:0] ST_OFS   = 7'(STATUS_OFS);
  localparam logic [6:0] PT_OFS   = 7'(FSR_OFS);

  logic direct_ext;
  assign direct_ext = (acc_addr != 7'd0) && (acc_addr < SFR_END) &&
                      (acc_addr != ST_OFS) && (acc_addr != PT_OFS);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!bank_sel && fsr_ptr == 8'h00));

  assert_status_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_addr == ST_OFS) |=> (bank_sel == $past(acc_wdata[BANK_BIT])));

  assert_fsr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_addr == PT_OFS) |=> (fsr_ptr == $past(acc_wdata)));

  assert_self_ptr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 7'd0 && fsr_ptr[6:0] == 7'd0) |-> (acc_rdata == 8'h00 && !sfr_we));

  assert_ext_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    direct_ext |-> (acc_rdata == sfr_rdata && sfr_addr == {bank_sel, acc_addr}));

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, acc_addr} >= UNIMP_LO) |-> (acc_rdata == 8'h00));

  assert_ext_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_we |-> (acc_we && sfr_addr[6:0] != 7'd0 && sfr_addr[6:0] < SFR_END &&
                sfr_addr[6:0] != ST_OFS && sfr_addr[6:0] != PT_OFS));
endmodule

bind banked_regfile banked_regfile_chk #(
  .GPR_BYTES(GPR_BYTES), .SFR_TOP(SFR_TOP), .STATUS_OFS(STATUS_OFS),
  .FSR_OFS(FSR_OFS), .BANK_BIT(BANK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_we(acc_we),
  .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .sfr_addr(sfr_addr),
  .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .bank_sel(bank_sel), .fsr_ptr(fsr_ptr)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  localparam int NG = 68;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] acc_addr = '0;
  logic       acc_we = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata, sfr_addr, sfr_wdata, sfr_rdata, fsr_ptr;
  logic       sfr_we, bank_sel;

  int errors = 0;
  int checks = 0;

  logic [7:0] m_gpr [NG];
  logic       m_bank = 1'b0;
  logic [7:0] m_fsr = 8'h00;

  always #5 clk = ~clk;

  assign sfr_rdata = sfr_addr ^ 8'hA5;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_we(acc_we),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .sfr_addr(sfr_addr),
    .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .bank_sel(bank_sel), .fsr_ptr(fsr_ptr)
  );

  function automatic logic [6:0] eff(input logic [6:0] a);
    return (a == 7'd0) ? m_fsr[6:0] : a;
  endfunction

  function automatic bit is_ext(input logic [6:0] e);
    return e != 0 && e < 12 && e != 3 && e != 4;
  endfunction

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    logic [6:0] e = eff(a);
    if (e == 0) return 8'h00;
    if (e == 3) return {2'b00, m_bank, 5'b00000};
    if (e == 4) return m_fsr;
    if (e < 12) return {m_bank, e} ^ 8'hA5;
    if (int'(e) - 12 < NG) return m_gpr[int'(e) - 12];
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [6:0] a);
    logic [6:0] e = eff(a);
    if (a == 0 && e == 0) return "R7";
    if (a == 0) return "R6";
    if (e == 3) return "R2";
    if (e == 4) return "R3";
    if (e < 12) return "R8";
    if (int'(e) - 12 < NG) return m_bank ? "R5" : "R4";
    return "R9";
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, expv);
    end
  endtask

  task automatic op(input logic [6:0] a, input logic w, input logic [7:0] d, input bit chk);
    logic [6:0] e;
    string t;
    @(negedge clk);
    acc_addr = a; acc_we = w; acc_wdata = d;
    #1;
    e = eff(a);
    t = tag_of(a);
    if (chk) check8(t, acc_rdata, exp_read(a));
    check8("R10", {7'd0, sfr_we}, {7'd0, w && is_ext(e)});
    if (is_ext(e)) begin
      check8("R8", sfr_addr, {m_bank, e});
      if (w) check8("R8", sfr_wdata, d);
    end
    @(posedge clk);
    if (w) begin
      if (e == 3) m_bank = d[5];
      else if (e == 4) m_fsr = d;
      else if (e >= 12 && int'(e) - 12 < NG) m_gpr[int'(e) - 12] = d;
    end
    #1;
    check8("R2", {7'd0, bank_sel}, {7'd0, m_bank});
    check8("R3", fsr_ptr, m_fsr);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check8("R1", {7'd0, bank_sel}, 8'h00);
    check8("R1", fsr_ptr, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check8("R1", {7'd0, bank_sel}, 8'h00);
    check8("R1", fsr_ptr, 8'h00);

    for (int i = 0; i < NG; i++) op(7'(12 + i), 1'b1, 8'(i * 7 + 3), 1'b0);

    // R2 / R5: bank 1 view of a bank 0 byte, then a write in bank 1 seen in bank 0
    op(7'h03, 1'b1, 8'h20, 1'b1);
    op(7'h0C, 1'b0, 8'h00, 1'b1);
    op(7'h20, 1'b1, 8'h5A, 1'b1);
    op(7'h03, 1'b1, 8'hDF, 1'b1);
    op(7'h20, 1'b0, 8'h00, 1'b1);
    // R6 indirect to a GPR byte in bank 0, then in bank 1
    op(7'h04, 1'b1, 8'h30, 1'b1);
    op(7'h00, 1'b1, 8'hC3, 1'b1);
    op(7'h30, 1'b0, 8'h00, 1'b1);
    op(7'h03, 1'b1, 8'hFF, 1'b1);
    op(7'h00, 1'b0, 8'h00, 1'b1);
    // R6 pointer bit 7 ignored in address formation
    op(7'h04, 1'b1, 8'hB0, 1'b1);
    op(7'h00, 1'b0, 8'h00, 1'b1);
    // R7 self-pointing indirect: read zero, write ignored
    op(7'h04, 1'b1, 8'h80, 1'b1);
    op(7'h00, 1'b1, 8'h77, 1'b1);
    op(7'h00, 1'b0, 8'h00, 1'b1);
    op(7'h04, 1'b0, 8'h00, 1'b1);
    // R8 external window in bank 1 and bank 0; GPR byte 0Ch untouched
    op(7'h0B, 1'b1, 8'h11, 1'b1);
    op(7'h01, 1'b0, 8'h00, 1'b1);
    op(7'h03, 1'b1, 8'h00, 1'b1);
    op(7'h05, 1'b1, 8'h22, 1'b1);
    op(7'h0C, 1'b0, 8'h00, 1'b1);
    // R9 unimplemented bytes, direct and indirect
    op(7'h50, 1'b1, 8'hEE, 1'b1);
    op(7'h50, 1'b0, 8'h00, 1'b1);
    op(7'h7F, 1'b1, 8'hEE, 1'b1);
    op(7'h04, 1'b1, 8'h7F, 1'b1);
    op(7'h00, 1'b0, 8'h00, 1'b1);
    // R4 boundary: last implemented byte
    op(7'h4F, 1'b1, 8'h9C, 1'b1);
    op(7'h4F, 1'b0, 8'h00, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 7);
      logic [6:0] a;
      logic [7:0] d = 8'($urandom);
      if (sel == 0) a = 7'h00;
      else if (sel == 1) a = 7'h03;
      else if (sel == 2) a = 7'h04;
      else a = 7'($urandom);
      op(a, 1'($urandom), d, 1'b1);
    end

    @(negedge clk);
    acc_we = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule